// File: doc/BRIEF.md
# Four-Mode Addressable Latch Bank

The block holds a small bank of single-bit storage cells, one per output, and serves them through a binary address, one serial data line and two active-low control lines. The pair of control lines picks one of four modes of operation. In the write mode, only the addressed cell takes the data line and every other cell keeps its value. In the hold mode, everything is frozen. In the steer mode, the data line reaches only the addressed output and the other outputs read zero. In the wipe mode, every output is forced to zero.

The cells are clocked registers. They capture on the clock edge that ends each cycle, and the outputs come from a combinational selector that mixes the stored cells with the live data line. As a result, the addressed output follows the data line within the same cycle in both the write mode and the steer mode. A low clear line also empties the stored cells at the clock edge, so leaving the steer mode or the wipe mode always starts from an all-zero bank. A typical use is to scatter a serial bit stream into parallel control flags, or to use the bank as a one-hot strobe generator.

Top module: `addr_latch_bank`

## Requirements
- R1: After `rst_n` has been low, all stored cells are zero, and in the hold mode every output reads 0.
- R2: Write mode is `en_n`=0 with `clr_n`=1. In this mode the output selected by `sel_addr` equals `din` in the same cycle.
- R3: In the write mode, the unaddressed outputs show their stored values. At the clock edge the addressed cell takes `din`, so after several write cycles the cell holds the last value written.
- R4: Hold mode is `en_n`=1 with `clr_n`=1. In this mode the outputs equal the stored cells and `din` has no effect on them.
- R5: Steer mode is `en_n`=0 with `clr_n`=0. In this mode the addressed output equals `din` and every other output is 0.
- R6: Wipe mode is `en_n`=1 with `clr_n`=0. In this mode all outputs are 0 whatever `sel_addr` and `din` are.
- R7: Every clock edge at which `clr_n` is 0 empties all stored cells, whether the mode is steer or wipe. The next hold cycle therefore reads all zeros.
- R8: `sel_addr` is a binary code with bit 0 as its least significant bit. Code k selects output bit `q[k]`.
- R9: `sel_addr` may change only in a hold cycle. Such a change leaves the outputs and the stored cells untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the cells capture on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the stored cells |
| sel_addr | input | ADDR_W (3) | Binary cell/output address |
| din | input | 1 | Serial data line |
| en_n | input | 1 | Active-low enable control |
| clr_n | input | 1 | Active-low clear control |
| q | output | 2**ADDR_W (8) | Bank outputs |

## Verification
The hardest case to reach is a clear that has emptied the storage while the outputs showed a steered one-hot pattern. This case only becomes visible when the bank returns to the hold mode afterwards. The stimulus therefore fills the bank with a non-zero pattern, runs a steer sweep over every address, and then holds, expecting zeros. It repeats the same sequence with the wipe mode. A pseudo-random phase mixes all four modes. It moves the address only through inserted hold cycles, so the addressing rule is respected while every ordering of modes still occurs.

// File: rtl/alb_pkg.sv
package alb_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_STEER = 2'd2,
    MODE_WIPE  = 2'd3
  } bank_mode_e;

  // en_n / clr_n pair -> operating mode
  function automatic bank_mode_e decode_mode(input logic en_n, input logic clr_n);
    bank_mode_e m;
    case ({en_n, clr_n})
      2'b01:   m = MODE_WRITE;
      2'b11:   m = MODE_HOLD;
      2'b00:   m = MODE_STEER;
      default: m = MODE_WIPE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/alb_mode_decode.sv
module alb_mode_decode
  import alb_pkg::*;
(
  input  logic       en_n,
  input  logic       clr_n,
  output bank_mode_e mode,
  output logic       wr_mode,
  output logic       hold_mode,
  output logic       steer_mode,
  output logic       wipe_mode
);
  always_comb begin
    mode       = decode_mode(en_n, clr_n);
    wr_mode    = (mode == MODE_WRITE);
    hold_mode  = (mode == MODE_HOLD);
    steer_mode = (mode == MODE_STEER);
    wipe_mode  = (mode == MODE_WIPE);
  end
endmodule

// File: rtl/alb_addr_decode.sv
module alb_addr_decode #(
  parameter int ADDR_W   = 3,
  parameter int NUM_BITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_BITS-1:0] sel
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/alb_store.sv
module alb_store #(
  parameter int NUM_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wipe,
  input  logic                wr_en,
  input  logic [NUM_BITS-1:0] sel,
  input  logic                din,
  output logic [NUM_BITS-1:0] stored
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                stored[i] <= 1'b0;
      else if (wipe)             stored[i] <= 1'b0;
      else if (wr_en && sel[i])  stored[i] <= din;
    end
  end
endmodule

// File: rtl/alb_out_mux.sv
module alb_out_mux
  import alb_pkg::*;
#(
  parameter int NUM_BITS = 8
) (
  input  bank_mode_e          mode,
  input  logic [NUM_BITS-1:0] sel,
  input  logic                din,
  input  logic [NUM_BITS-1:0] stored,
  output logic [NUM_BITS-1:0] q
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_out
    always_comb begin
      case (mode)
        MODE_WRITE: q[i] = sel[i] ? din : stored[i];
        MODE_HOLD:  q[i] = stored[i];
        MODE_STEER: q[i] = sel[i] & din;
        default:    q[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import alb_pkg::*;
#(
  parameter int ADDR_W   = 3,
  localparam int NUM_BITS = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   sel_addr,
  input  logic                din,
  input  logic                en_n,
  input  logic                clr_n,
  output logic [NUM_BITS-1:0] q
);
  bank_mode_e          mode;
  logic                wr_mode, hold_mode, steer_mode, wipe_mode;
  logic                wipe_evt;
  logic [NUM_BITS-1:0] sel;
  logic [NUM_BITS-1:0] stored;

  assign wipe_evt = steer_mode | wipe_mode;

  alb_mode_decode u_mode (
    .en_n(en_n), .clr_n(clr_n), .mode(mode),
    .wr_mode(wr_mode), .hold_mode(hold_mode),
    .steer_mode(steer_mode), .wipe_mode(wipe_mode)
  );

  alb_addr_decode #(.ADDR_W(ADDR_W), .NUM_BITS(NUM_BITS)) u_dec (
    .addr(sel_addr), .sel(sel)
  );

  alb_store #(.NUM_BITS(NUM_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .wipe(wipe_evt), .wr_en(wr_mode),
    .sel(sel), .din(din), .stored(stored)
  );

  alb_out_mux #(.NUM_BITS(NUM_BITS)) u_mux (
    .mode(mode), .sel(sel), .din(din), .stored(stored), .q(q)
  );
endmodule

// File: rtl/alb_checker.sv
module alb_checker #(
  parameter int ADDR_W   = 3,
  parameter int NUM_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   sel_addr,
  input logic                din,
  input logic                clr_n,
  input logic [NUM_BITS-1:0] q,
  input logic [NUM_BITS-1:0] stored,
  input logic                wr_mode,
  input logic                hold_mode,
  input logic                steer_mode,
  input logic                wipe_mode
);
  a_r2_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |-> q[sel_addr] == din);

  a_r3_write_captures: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> stored[$past(sel_addr)] == $past(din));

  a_r4_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && $past(hold_mode)) |-> $stable(q));

  a_r5_steer_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    steer_mode |-> ($onehot0(q) && q[sel_addr] == din));

  a_r6_wipe_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_mode |-> q == '0);

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> stored == '0);

  a_r9_addr_only_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_mode && !$past(hold_mode)) |-> $stable(sel_addr));
endmodule

bind addr_latch_bank alb_checker #(.ADDR_W(ADDR_W), .NUM_BITS(NUM_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr), .din(din), .clr_n(clr_n),
  .q(q), .stored(stored), .wr_mode(wr_mode), .hold_mode(hold_mode),
  .steer_mode(steer_mode), .wipe_mode(wipe_mode)
);

// File: tb/addr_latch_bank_test.sv
module addr_latch_bank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel_addr = 3'd0;
  logic       din = 1'b0;
  logic       en_n = 1'b1;
  logic       clr_n = 1'b1;
  logic [7:0] q;

  int checks = 0;
  int fails  = 0;
  bit [7:0] ref_cells = 8'h00;   // behavioural model of stored bits
  bit       after_clear = 0;     // next hold is expected empty (R7)

  always #5 clk = ~clk;

  addr_latch_bank uut (
    .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr), .din(din),
    .en_n(en_n), .clr_n(clr_n), .q(q)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: q=%b expected %b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare before the rising edge, then update model
  task automatic cyc(input bit e, input bit c, input logic [2:0] a, input bit d, input string extra);
    bit [7:0] exp;
    string    tag;
    @(negedge clk);
    en_n = e; clr_n = c; sel_addr = a; din = d;
    #1;
    case ({e, c})
      2'b01: begin exp = (ref_cells & ~(8'h1 << a)) | (8'(d) << a); tag = "R3"; end
      2'b11: begin exp = ref_cells; tag = after_clear ? "R7" : "R4"; end
      2'b00: begin exp = 8'(d) << a; tag = "R5"; end
      default: begin exp = 8'h00; tag = "R6"; end
    endcase
    if (extra != "") tag = extra;
    check(tag, q, exp);
    if ({e, c} == 2'b01) check("R2", {7'd0, q[a]}, {7'd0, d});
    if (!c) begin ref_cells = 8'h00; after_clear = 1; end
    else begin
      if (!e) ref_cells[a] = d;
      if (!e) after_clear = 0;
    end
  endtask

  // mode step honouring R9: a new address is first presented in a hold cycle
  task automatic step(input bit e, input bit c, input logic [2:0] a, input bit d);
    if (a != sel_addr) cyc(1'b1, 1'b1, a, ~d, "R9");
    cyc(e, c, a, d, "");
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit [7:0] lfsr = 8'h5D;
    repeat (3) @(negedge clk);
    #1 check("R1", q, 8'h00);
    rst_n = 1'b1;
    cyc(1'b1, 1'b1, 3'd0, 1'b1, "R1");

    // fill pattern 0xA5 bit by bit
    for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 3'(k), (8'hA5 >> k) & 1'b1);
    cyc(1'b1, 1'b1, 3'd7, 1'b1, "R4");
    cyc(1'b1, 1'b1, 3'd7, 1'b0, "R4");

    // repeated writes on one address: last one sticks (R3)
    step(1'b0, 1'b1, 3'd2, 1'b1);
    cyc(1'b0, 1'b1, 3'd2, 1'b0, "");
    cyc(1'b0, 1'b1, 3'd2, 1'b1, "");
    cyc(1'b1, 1'b1, 3'd2, 1'b0, "R3");

    // steer sweep: one-hot per code (R8), then empty bank on hold (R7)
    for (int k = 0; k < 8; k++) begin
      if (3'(k) != sel_addr) cyc(1'b1, 1'b1, 3'(k), 1'b0, "R9");
      cyc(1'b0, 1'b0, 3'(k), 1'b1, "R8");
      cyc(1'b0, 1'b0, 3'(k), 1'b0, "R5");
    end
    cyc(1'b1, 1'b1, 3'd7, 1'b1, "R7");

    // refill, then wipe with varied data, then hold
    for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 3'(k), 1'b1);
    cyc(1'b1, 1'b1, 3'd7, 1'b0, "R4");
    cyc(1'b1, 1'b0, 3'd7, 1'b1, "R6");
    cyc(1'b1, 1'b0, 3'd7, 1'b0, "R6");
    cyc(1'b1, 1'b1, 3'd7, 1'b1, "R7");

    // single bit per code after the wipe: q == 1<<k (R8)
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 1'b1, 3'(k), 1'b1);
      cyc(1'b1, 1'b1, 3'(k), 1'b0, "R8");
      step(1'b0, 1'b1, 3'(k), 1'b0);
    end

    // pseudo-random mode mix
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], lfsr[1] | lfsr[6], lfsr[4:2], lfsr[7]);
    end

    cyc(1'b1, 1'b1, sel_addr, 1'b0, "");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule